// File: doc/BRIEF.md
# ADC Control and Result Register Front End

This block is the digital register face of a 10-bit successive-approximation converter inside a microcontroller. It holds one 8-bit control register, written and read over a simple single-cycle bus port. The register carries a reference-source selector, a result-justification flag and a channel/gain selector. The analog core sits outside the block and is represented only by a busy level, a completion strobe and a 10-bit result.

The block keeps the most recent conversion result and raises a completion flag. It presents the result as a high byte and a low byte, packed toward either the top or the bottom of the 16 bits. Two control fields follow different timing rules. A change of reference source made while a conversion is running is held back until that conversion completes. A change of justification re-packs the stored result at once.

Top module: `adc_reg_front`

## Requirements
- R1: After reset the control readback, result bytes, completion flag, active reference and reserved-code flag are all zero.
- R2: A write (wr_en_i high at a clock edge) stores wr_data_i in the control register, which reads back on rd_data_o from the next cycle. Bits 7:6 are the reference selector, bit 5 is the left-justify flag and bits 4:0 drive chan_sel_o.
- R3: While conv_busy_i is high and conv_done_i is low, ref_sel_o keeps its value, whatever is written. At the edge where conv_done_i is high, ref_sel_o takes the register's reference field.
- R4: While conv_busy_i is low, ref_sel_o follows the register's reference field with the same one-edge latency as rd_data_o.
- R5: On the edge where conv_done_i is high, the result is stored and done_flag_o is set. flag_clr_i clears the flag, and a strobe in the same cycle wins over a clear.
- R6: With the left-justify flag at 0, res_hi_o holds result bits 9:8 in its bits 1:0 with its upper bits zero, and res_lo_o holds result bits 7:0. For example, 0x270 reads as 0x02 and 0x70.
- R7: With the left-justify flag at 1, res_hi_o holds result bits 9:2, and res_lo_o holds result bits 1:0 in its bits 7:6 with its lower bits zero. For example, 0x270 reads as 0x9C and 0x00. Results are 10-bit two's complement: 0x1FF is +511, 0x3FF is -1 and 0x200 is -512.
- R8: Toggling the left-justify flag re-packs an already stored result from the cycle after the write, with no new conversion.
- R9: Reference code 2'b10 is reserved. It is stored and read back unchanged, and ref_rsvd_o is high while the register holds it.
- R10: conv_result_i has no effect on the result bytes in cycles without conv_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write enable |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register readback |
| conv_busy_i | input | 1 | Conversion in progress |
| conv_done_i | input | 1 | Conversion complete strobe |
| conv_result_i | input | 10 | Raw conversion result |
| flag_clr_i | input | 1 | Clears the completion flag |
| done_flag_o | output | 1 | Completion flag |
| res_hi_o | output | 8 | High result byte |
| res_lo_o | output | 8 | Low result byte |
| ref_sel_o | output | 2 | Active reference selection |
| chan_sel_o | output | 5 | Channel/gain selection |
| ref_rsvd_o | output | 1 | Reserved reference code held |

## Verification
Every registered result is due one edge after its stimulus: register readback, active reference, stored result and flag. Re-packing after a justify change comes with that register write, so it is due at the same time. The bench drives inputs on the falling edge. It advances a behavioural model on the rising edge, using the same inputs the design sees, and compares every output on the next falling edge. The directed steps check named values at that same point, one edge after their stimulus. A reference write inside a busy window is checked on each held cycle, and again on the cycle after the strobe.

// File: rtl/adc_front_pkg.sv
package adc_front_pkg;
  localparam int BYTE_W = 8;
  localparam int RES_W  = 10;
  localparam int REF_W  = 2;
  localparam int CHAN_W = 5;
  localparam int PACK_W = 2 * BYTE_W;
  localparam int PAD_W  = PACK_W - RES_W;

  typedef struct packed {
    logic [REF_W-1:0]  ref_sel;
    logic              left_adj;
    logic [CHAN_W-1:0] chan;
  } ctrl_t;

  localparam logic [REF_W-1:0] REF_RSVD = 2'b10;
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_front_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output ctrl_t             ctrl_q_o,
  output ctrl_t             ctrl_d_o
);
  ctrl_t ctrl_q;

  assign ctrl_d_o = wr_en_i ? ctrl_t'(wr_data_i) : ctrl_q;
  assign ctrl_q_o = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d_o;
  end

  p_wr_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ctrl_q == ctrl_t'($past(wr_data_i))));
endmodule

// File: rtl/adc_ref_shadow.sv
module adc_ref_shadow
  import adc_front_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [REF_W-1:0] ref_next_i,
  output logic [REF_W-1:0] ref_act_o
);
  logic [REF_W-1:0] ref_q;
  logic             take;

  // idle: track the register; busy: hold until completion edge
  assign take = !busy_i || done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ref_q <= '0;
    else if (take) ref_q <= ref_next_i;
  end

  assign ref_act_o = ref_q;

  p_ref_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> $stable(ref_act_o));
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_front_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              clr_i,
  input  logic [RES_W-1:0]  result_i,
  input  logic              left_adj_i,
  output logic              flag_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  logic [RES_W-1:0]  res_q;
  logic              flag_q;
  logic [PACK_W-1:0] packed_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (done_i) res_q <= result_i;
      if (done_i)     flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (left_adj_i) packed_w = {res_q, {PAD_W{1'b0}}};
        else            packed_w = {{PAD_W{1'b0}}, res_q};
      end
    end else begin : g_nopad
      assign packed_w = res_q;
    end
  endgenerate

  assign hi_o   = packed_w[PACK_W-1:BYTE_W];
  assign lo_o   = packed_w[BYTE_W-1:0];
  assign flag_o = flag_q;

  p_res_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(res_q));
  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> flag_o);
  p_flag_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !done_i) |=> !flag_o);
endmodule

// File: rtl/adc_reg_front.sv
module adc_reg_front
  import adc_front_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              conv_busy_i,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i,
  input  logic              flag_clr_i,
  output logic              done_flag_o,
  output logic [BYTE_W-1:0] res_hi_o,
  output logic [BYTE_W-1:0] res_lo_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic [CHAN_W-1:0] chan_sel_o,
  output logic              ref_rsvd_o
);
  ctrl_t ctrl_q, ctrl_d;

  adc_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .ctrl_q_o (ctrl_q),
    .ctrl_d_o (ctrl_d)
  );

  adc_ref_shadow u_ref (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (conv_busy_i),
    .done_i    (conv_done_i),
    .ref_next_i(ctrl_d.ref_sel),
    .ref_act_o (ref_sel_o)
  );

  adc_result_fmt u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (conv_done_i),
    .clr_i     (flag_clr_i),
    .result_i  (conv_result_i),
    .left_adj_i(ctrl_q.left_adj),
    .flag_o    (done_flag_o),
    .hi_o      (res_hi_o),
    .lo_o      (res_lo_o)
  );

  assign rd_data_o  = ctrl_q;
  assign chan_sel_o = ctrl_q.chan;
  assign ref_rsvd_o = (ctrl_q.ref_sel == REF_RSVD);

  p_ref_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_busy_i |=> (ref_sel_o == rd_data_o[BYTE_W-1 -: REF_W]));
  p_ref_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> (ref_sel_o == rd_data_o[BYTE_W-1 -: REF_W]));
  p_pad_right_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[CHAN_W] |-> (res_hi_o[BYTE_W-1:RES_W-BYTE_W] == '0));
  p_pad_left_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[CHAN_W] |-> (res_lo_o[PACK_W-RES_W-1:0] == '0));
endmodule

// File: tb/adc_reg_front_tb.sv
module adc_reg_front_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       busy = 1'b0;
  logic       done = 1'b0;
  logic [9:0] result = '0;
  logic       clr = 1'b0;
  logic [7:0] rd_data, res_hi, res_lo;
  logic       flag, rsvd;
  logic [1:0] ref_sel;
  logic [4:0] chan;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural model state
  logic [7:0] m_ctrl = '0;
  logic [1:0] m_ref = '0;
  logic [9:0] m_res = '0;
  logic       m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_reg_front dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .conv_busy_i(busy), .conv_done_i(done), .conv_result_i(result),
    .flag_clr_i(clr), .done_flag_o(flag),
    .res_hi_o(res_hi), .res_lo_o(res_lo),
    .ref_sel_o(ref_sel), .chan_sel_o(chan), .ref_rsvd_o(rsvd)
  );

  function automatic logic [15:0] pack16(input logic [9:0] r, input logic left);
    int v;
    v = left ? int'(r) * 64 : int'(r);
    return v[15:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] nxt;
    if (!rst_n) begin
      m_ctrl = '0; m_ref = '0; m_res = '0; m_flag = 1'b0;
    end else begin
      nxt = wr_en ? wr_data : m_ctrl;
      if (!busy || done) m_ref = nxt[7:6];
      if (done) begin m_res = result; m_flag = 1'b1; end
      else if (clr) m_flag = 1'b0;
      m_ctrl = nxt;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [15:0] p;
    if (rst_n && !finished) begin
      p = pack16(m_res, m_ctrl[5]);
      check("R2 readback", rd_data, m_ctrl);
      check("R2 chan", chan, m_ctrl[4:0]);
      check("R3/R4 ref", ref_sel, m_ref);
      check("R5 flag", flag, m_flag);
      check("R6/R7/R8/R10 hi", res_hi, p[15:8]);
      check("R6/R7/R8/R10 lo", res_lo, p[7:0]);
      check("R9 rsvd", rsvd, m_ctrl[7:6] == 2'b10);
    end
  end

  task automatic cyc(input logic we, input logic [7:0] wd, input logic b,
                     input logic d, input logic [9:0] r, input logic c);
    @(negedge clk);
    wr_en = we; wr_data = wd; busy = b; done = d; result = r; clr = c;
  endtask

  task automatic settle;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic summary;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R1 reset state
    check("R1 rd", rd_data, 0); check("R1 hi", res_hi, 0);
    check("R1 lo", res_lo, 0); check("R1 flag", flag, 0);
    check("R1 ref", ref_sel, 0); check("R1 rsvd", rsvd, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R4 idle write: ref 01, right adjust, chan 5
    cyc(1, 8'h45, 0, 0, 10'h000, 0); settle();
    check("R2 rd", rd_data, 8'h45); check("R2 chan", chan, 5);
    check("R4 ref", ref_sel, 2'b01);

    // R3: busy window, reference write held; R10: result ignored without strobe
    cyc(1, 8'hC5, 1, 0, 10'h155, 0);
    for (int i = 0; i < 4; i++) begin
      settle();
      check("R3 ref held", ref_sel, 2'b01);
      check("R10 hi", res_hi, 0); check("R10 lo", res_lo, 0);
      cyc(0, 8'h00, 1, 0, 10'h2AA + 10'(i), 0);
    end
    cyc(0, 8'h00, 1, 1, 10'h270, 0); settle();
    check("R3 ref applied", ref_sel, 2'b11);
    check("R5 flag set", flag, 1);
    check("R6 hi", res_hi, 8'h02); check("R6 lo", res_lo, 8'h70);

    // R8/R7: left justify re-packs stored result
    cyc(1, 8'hE5, 0, 0, 10'h000, 0); settle();
    check("R8 hi", res_hi, 8'h9C); check("R8 lo", res_lo, 8'h00);

    // R5 clear, then strobe beats clear
    cyc(0, 8'h00, 0, 0, 10'h000, 1); settle();
    check("R5 clr", flag, 0);
    cyc(0, 8'h00, 1, 1, 10'h1FF, 1); settle();
    check("R5 done over clr", flag, 1);
    check("R7 +511 hi", res_hi, 8'h7F); check("R7 +511 lo", res_lo, 8'hC0);
    cyc(0, 8'h00, 1, 1, 10'h200, 0); settle();
    check("R7 -512 hi", res_hi, 8'h80); check("R7 -512 lo", res_lo, 8'h00);
    cyc(1, 8'h05, 0, 1, 10'h3FF, 0); settle();
    check("R6 -1 hi", res_hi, 8'h03); check("R6 -1 lo", res_lo, 8'hFF);

    // R9 reserved code
    cyc(1, 8'h80, 0, 0, 10'h000, 0); settle();
    check("R9 rd", rd_data, 8'h80); check("R9 rsvd", rsvd, 1);
    check("R9 ref", ref_sel, 2'b10);

    // mixed traffic, checked by the model
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 4) == 0, 8'($urandom), ($urandom % 3) != 0,
          ($urandom % 6) == 0, 10'($urandom), ($urandom % 5) == 0);
    end
    cyc(0, 8'h00, 0, 0, 10'h000, 0);
    settle();
    summary();
  end
endmodule